// File: doc/BRIEF.md
# Sign-Magnitude Accumulator Unit with Background Multiply and Divide

This block executes accumulator instructions on 26-bit sign-magnitude words. Bit 25 is the sign and bits 24:0 are the magnitude. Each cycle a controller may present an opcode and a memory operand with a `go` strobe. An instruction is taken at the rising edge where `go` is high and `stall` is low. Simple operations update the accumulator at that edge. These are add, subtract, reverse subtract, bitwise AND and XOR, a short shift that can also clear, and a store that hands the accumulator to the memory side.

Multiply and divide run in a shared engine for a fixed number of cycles. The background forms write a dedicated result register and let later instructions proceed. A second multiply form holds the unit until the product is ready and then loads it into the accumulator. A separate instruction copies the result register into the accumulator. That instruction, and any new multiply or divide, waits while the engine is still working. One clock is one instruction cycle.

Top module: `acc_unit`

## Requirements
- R1: After synchronous reset the accumulator and result register are 0, `zero` is 1, `neg` is 0 and `stall` is 0.
- R2: Opcode 1 (add) and opcode 2 (subtract) form accumulator plus operand and accumulator minus operand in sign-magnitude. A magnitude overflow saturates to 0x1FFFFFF while keeping the sign.
- R3: Opcode 3 (reverse subtract) leaves operand minus accumulator in the accumulator.
- R4: Opcode 4 (AND) and opcode 5 (XOR) combine all 26 bits of the accumulator and operand bitwise.
- R5: Opcode 7 (shift) uses operand bits 1:0. The code 01 shifts the magnitude left 1, 10 shifts it left 2, 11 shifts it right 1, and 00 clears the accumulator. The sign is kept, bits shifted out are lost, and the other operand bits are ignored.
- R6: Opcode 8 (background multiply) writes the result register 4 cycles after acceptance, without stalling later instructions or touching the accumulator. The result magnitude is bits 49:25 of the 50-bit magnitude product, and its sign is the XOR of the operand signs.
- R7: Opcode 9 (background divide) writes the result register 8 cycles after acceptance with magnitude (acc_mag * 2^25) / operand_mag. The magnitude saturates to 0x1FFFFFF when the divisor magnitude is 0 or not larger than the accumulator magnitude. The sign is the XOR of the operand signs.
- R8: Opcode 10 (stalling multiply) holds `stall` high for 4 cycles after acceptance and then loads the product, formed as in R6, into both the accumulator and the result register.
- R9: Opcodes 8, 9, 10 and 11 (opcode 11 copies the result register into the accumulator) stall while the engine is busy and are taken in the cycle after it finishes.
- R10: No result is ever negative zero; a zero magnitude always carries a positive sign. `zero` flags an all-zero accumulator and `neg` reflects bit 25.
- R11: Opcode 6 (store) drives `store_we` high while accepted, with `store_data` equal to the accumulator, and leaves the accumulator unchanged. Opcode 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Instruction strobe |
| opcode | input | 4 | Operation code |
| operand | input | 26 | Memory operand, sign-magnitude |
| stall | output | 1 | Instruction not taken this cycle |
| store_we | output | 1 | Store write enable |
| store_data | output | 26 | Store write data |
| acc | output | 26 | Accumulator |
| zero | output | 1 | Accumulator is zero |
| neg | output | 1 | Accumulator sign |
| res | output | 26 | Multiply/divide result register |

## Verification
The hardest situation to reach is overlap: an instruction arriving while the engine is still counting. It has to be checked both when it should pass and when it should wait. The stimulus issues a background multiply and immediately follows it with an add that must not stall. It then issues a divide and at once a result read, which must be held for exactly the eight busy cycles. After a stalling multiply, an add is presented back to back and its stall length is counted. Each wait is compared against the cycle counts in the requirements.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int W     = 26;
    localparam int MAG_W = W - 1;
    localparam int SB    = W - 1;

    typedef logic [W-1:0]     word_t;
    typedef logic [MAG_W-1:0] mag_t;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_RSB = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_STO = 4'd6,
        OP_SHF = 4'd7,
        OP_MPY = 4'd8,
        OP_DIV = 4'd9,
        OP_MPH = 4'd10,
        OP_RDR = 4'd11
    } op_t;

    function automatic word_t norm(word_t v);
        return (v[MAG_W-1:0] == '0) ? '0 : v;
    endfunction

    function automatic word_t flip(word_t v);
        return {~v[SB], v[MAG_W-1:0]};
    endfunction

    function automatic word_t sm_add(word_t a, word_t b);
        logic [MAG_W:0] s;
        word_t r;
        if (a[SB] == b[SB]) begin
            s = {1'b0, a[MAG_W-1:0]} + {1'b0, b[MAG_W-1:0]};
            r = {a[SB], s[MAG_W] ? {MAG_W{1'b1}} : s[MAG_W-1:0]};
        end else if (a[MAG_W-1:0] >= b[MAG_W-1:0]) begin
            r = {a[SB], a[MAG_W-1:0] - b[MAG_W-1:0]};
        end else begin
            r = {b[SB], b[MAG_W-1:0] - a[MAG_W-1:0]};
        end
        return norm(r);
    endfunction

    function automatic word_t sm_mul(word_t a, word_t b);
        logic [2*MAG_W-1:0] p;
        p = {{MAG_W{1'b0}}, a[MAG_W-1:0]} * {{MAG_W{1'b0}}, b[MAG_W-1:0]};
        return norm({a[SB] ^ b[SB], p[2*MAG_W-1:MAG_W]});
    endfunction

    function automatic word_t sm_div(word_t a, word_t b);
        logic [2*MAG_W-1:0] n;
        logic [2*MAG_W-1:0] d;
        logic [2*MAG_W-1:0] q;
        mag_t m;
        n = {a[MAG_W-1:0], {MAG_W{1'b0}}};
        d = {{MAG_W{1'b0}}, b[MAG_W-1:0]};
        if (b[MAG_W-1:0] == '0 || a[MAG_W-1:0] >= b[MAG_W-1:0]) begin
            m = '1;
        end else begin
            q = n / d;
            m = q[MAG_W-1:0];
        end
        return norm({a[SB] ^ b[SB], m});
    endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  op_t   op,
    input  word_t a,
    input  word_t b,
    output word_t y,
    output logic  wr
);

    mag_t am;
    assign am = a[MAG_W-1:0];

    always_comb begin
        y  = a;
        wr = 1'b1;
        unique case (op)
            OP_ADD: y = sm_add(a, b);
            OP_SUB: y = sm_add(a, flip(b));
            OP_RSB: y = sm_add(b, flip(a));
            OP_AND: y = norm(a & b);
            OP_XOR: y = norm(a ^ b);
            OP_SHF: begin
                unique case (b[1:0])
                    2'b01:   y = norm({a[SB], am[MAG_W-2:0], 1'b0});
                    2'b10:   y = norm({a[SB], am[MAG_W-3:0], 2'b00});
                    2'b11:   y = norm({a[SB], 1'b0, am[MAG_W-1:1]});
                    default: y = '0;
                endcase
            end
            default: wr = 1'b0;
        endcase
    end

endmodule

// File: rtl/md_engine.sv
module md_engine
    import acc_pkg::*;
#(
    parameter int MUL_CYC = 4,
    parameter int DIV_CYC = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  is_div,
    input  word_t a,
    input  word_t b,
    output logic  busy,
    output logic  done,
    output word_t next_res,
    output word_t res
);

    localparam int MAX_CYC = (MUL_CYC > DIV_CYC) ? MUL_CYC : DIV_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;
    logic          mode_div;
    word_t         opa, opb;

    assign done     = busy && (cnt == '0);
    assign next_res = mode_div ? sm_div(opa, opb) : sm_mul(opa, opb);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            mode_div <= 1'b0;
            opa      <= '0;
            opb      <= '0;
            res      <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            cnt      <= is_div ? CW'(DIV_CYC - 1) : CW'(MUL_CYC - 1);
            mode_div <= is_div;
            opa      <= a;
            opb      <= b;
        end else if (done) begin
            busy <= 1'b0;
            res  <= next_res;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    a_r9_no_start_while_busy: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    a_r6_res_moves_on_completion: assert property (@(posedge clk) disable iff (rst)
        !$stable(res) |-> $past(busy));

endmodule

// File: rtl/acc_unit.sv
module acc_unit
    import acc_pkg::*;
#(
    parameter int MUL_CYC = 4,
    parameter int DIV_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [3:0]    opcode,
    input  logic [W-1:0]  operand,
    output logic          stall,
    output logic          store_we,
    output logic [W-1:0]  store_data,
    output logic [W-1:0]  acc,
    output logic          zero,
    output logic          neg,
    output logic [W-1:0]  res
);

    op_t   op;
    logic  needs_eng, accept, hold;
    logic  eng_busy, eng_done, eng_start;
    word_t eng_next, alu_y;
    logic  alu_wr;

    assign op        = op_t'(opcode);
    assign needs_eng = (op == OP_MPY) || (op == OP_DIV) || (op == OP_MPH) || (op == OP_RDR);
    assign stall     = hold || (go && needs_eng && eng_busy);
    assign accept    = go && !stall;
    assign eng_start = accept && ((op == OP_MPY) || (op == OP_DIV) || (op == OP_MPH));

    assign store_we   = accept && (op == OP_STO);
    assign store_data = acc;
    assign zero       = (acc == '0);
    assign neg        = acc[SB];

    acc_alu u_alu (
        .op (op),
        .a  (acc),
        .b  (operand),
        .y  (alu_y),
        .wr (alu_wr)
    );

    md_engine #(.MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .is_div   (op == OP_DIV),
        .a        (acc),
        .b        (operand),
        .busy     (eng_busy),
        .done     (eng_done),
        .next_res (eng_next),
        .res      (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            hold <= 1'b0;
        end else begin
            if (hold && eng_done) begin
                acc  <= eng_next;
                hold <= 1'b0;
            end else if (accept && op == OP_MPH) begin
                hold <= 1'b1;
            end else if (accept && op == OP_RDR) begin
                acc <= res;
            end else if (accept && alu_wr) begin
                acc <= alu_y;
            end
        end
    end

    a_r8_hold_stalls: assert property (@(posedge clk) disable iff (rst)
        hold |-> stall);

    a_r8_release_with_engine: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> !eng_busy);

    a_r9_conflict_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (stall && !hold) |=> $stable(acc));

    a_r10_no_negzero: assert property (@(posedge clk) disable iff (rst)
        (acc[MAG_W-1:0] == '0) |-> !acc[SB]);

    a_r11_store_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        store_we |=> $stable(acc));

endmodule

// File: tb/sim_acc_unit.sv
module sim_acc_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic [25:0] operand = '0;
    logic        stall, store_we, zero, neg;
    logic [25:0] store_data, acc, res;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    acc_unit u0 (
        .clk(clk), .rst(rst), .go(go), .opcode(opcode), .operand(operand),
        .stall(stall), .store_we(store_we), .store_data(store_data),
        .acc(acc), .zero(zero), .neg(neg), .res(res)
    );

    // {opcode, start value, operand, expected accumulator}
    localparam logic [81:0] VEC [14] = '{
        {4'd1, 26'h0000005, 26'h0000003, 26'h0000008},
        {4'd1, 26'h0000005, 26'h2000007, 26'h2000002},
        {4'd2, 26'h0000005, 26'h0000005, 26'h0000000},
        {4'd2, 26'h2000003, 26'h0000004, 26'h2000007},
        {4'd3, 26'h000000A, 26'h0000003, 26'h2000007},
        {4'd4, 26'h00000F0, 26'h2000FF0, 26'h00000F0},
        {4'd4, 26'h2000001, 26'h2000002, 26'h0000000},
        {4'd5, 26'h0000005, 26'h2000003, 26'h2000006},
        {4'd7, 26'h0000003, 26'h0000101, 26'h0000006},
        {4'd7, 26'h1800001, 26'h0000002, 26'h0000004},
        {4'd7, 26'h2000007, 26'h0000003, 26'h2000003},
        {4'd7, 26'h2000007, 26'h0000000, 26'h0000000},
        {4'd7, 26'h2000001, 26'h0000003, 26'h0000000},
        {4'd1, 26'h1FFFFFF, 26'h0000001, 26'h1FFFFFF}
    };

    task automatic check(input bit ok, input string req, input logic [25:0] act,
                         input logic [25:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic issue(input logic [3:0] op, input logic [25:0] val, output int stalls);
        stalls = 0;
        go = 1'b1;
        opcode = op;
        operand = val;
        #1;
        while (stall) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        go = 1'b0;
        opcode = 4'd0;
        operand = '0;
    endtask

    task automatic load(input logic [25:0] v);
        int s;
        issue(4'd7, 26'd0, s);
        issue(4'd1, v, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 26'd0, 26'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(acc == 0 && res == 0, "R1 acc/res", acc, 26'd0);
        check(zero && !neg && !stall, "R1 flags", {23'd0, zero, neg, stall}, 26'h4);
        @(negedge clk);

        // R2 R3 R4 R5 R10 vector walk
        foreach (VEC[i]) begin
            load(VEC[i][77:52]);
            issue(VEC[i][81:78], VEC[i][51:26], s);
            check(acc == VEC[i][25:0], "R2/R3/R4/R5/R10 vector", acc, VEC[i][25:0]);
            check(zero == (VEC[i][25:0] == 0) && neg == VEC[i][25], "R10 flags",
                  {24'd0, zero, neg}, {24'd0, VEC[i][25:0] == 0, VEC[i][25]});
        end

        // R6 background multiply overlapped with an add
        load(26'h1000000);
        issue(4'd8, 26'h3000000, s);
        check(acc == 26'h1000000 && res == 0, "R6 acc untouched", acc, 26'h1000000);
        issue(4'd1, 26'h0000001, s);
        check(s == 0, "R6 no stall for add", 26'(s), 26'd0);
        check(acc == 26'h1000001, "R6 add during multiply", acc, 26'h1000001);
        @(negedge clk);
        @(negedge clk);
        check(res == 0, "R6 result not yet written", res, 26'd0);
        @(negedge clk);
        check(res == 26'h2800000, "R6 product", res, 26'h2800000);

        // R7 R9 divide then immediate read of the result register
        load(26'h0800000);
        issue(4'd9, 26'h1000000, s);
        issue(4'd11, 26'd0, s);
        check(s == 8, "R9 read stalls during divide", 26'(s), 26'd8);
        check(acc == 26'h1000000, "R7 quotient", acc, 26'h1000000);

        // R7 divide by zero saturates, negative dividend
        load(26'h2000001);
        issue(4'd9, 26'h0000002, s);
        issue(4'd11, 26'd0, s);
        check(acc == 26'h3000000, "R7 signed quotient", acc, 26'h3000000);
        load(26'h0000005);
        issue(4'd9, 26'h0000000, s);
        issue(4'd11, 26'd0, s);
        check(acc == 26'h1FFFFFF, "R7 zero divisor", acc, 26'h1FFFFFF);

        // R9 back-to-back multiplies
        load(26'h0000001);
        issue(4'd8, 26'h0000001, s);
        issue(4'd8, 26'h0000001, s);
        check(s == 4, "R9 second multiply waits", 26'(s), 26'd4);

        // R8 stalling multiply
        repeat (5) @(negedge clk);
        load(26'h1000000);
        issue(4'd10, 26'h1000000, s);
        check(stall, "R8 stall after accept", {25'd0, stall}, 26'd1);
        issue(4'd1, 26'd0, s);
        check(s == 4, "R8 stall length", 26'(s), 26'd4);
        check(acc == 26'h0800000 && res == 26'h0800000, "R8 product in acc", acc, 26'h0800000);

        // R11 store and nop
        load(26'h2000123);
        go = 1'b1; opcode = 4'd6; operand = 26'h0000777;
        #1;
        check(store_we && store_data == 26'h2000123, "R11 store", store_data, 26'h2000123);
        @(negedge clk);
        go = 1'b0; opcode = 4'd0;
        #1;
        check(!store_we && acc == 26'h2000123, "R11 acc kept", acc, 26'h2000123);
        @(negedge clk);
        issue(4'd0, 26'h0000055, s);
        check(acc == 26'h2000123, "R11 nop", acc, 26'h2000123);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule